// File: doc/BRIEF.md
# Twisted-Pair Attachment Loopback and Status Controller

This block steers the data paths of a twisted-pair medium attachment unit and raises its activity flags. On one side sit the station-facing attachment pairs: the outbound data the station sends, and the inbound data and control signals sent back toward it. On the other side sit the twisted-pair transmitter and receiver. The block only decides which source feeds each driver and when each driver is on. It never handles the line signals themselves.

A single test input picks normal operation or loopback. In loopback, the heartbeat-enable input then picks one of two routings. Station-style routing keeps the two directions apart. Repeater-style routing turns each side's data back onto the same side. In normal operation the block signals a collision when both paths are busy at once. When the heartbeat test is enabled and the link is good, it sends a fixed-length control burst after every transmission ends. All outputs are registered: each reflects the inputs sampled at the previous clock edge. Reset is applied asynchronously and released through a synchronizer.

Top module: `mau_loop_ctrl`

## Requirements
- R1: While `rst_n` is low, every output is 0. After `rst_n` rises, outputs stay 0 until the reset synchronizer (RST_STAGES flops) has released.
- R2: With `tp_test` high (normal mode), `tx_src` and `di_src` are 0. `tx_en` follows `aui_do_act` and `di_en` follows `tp_rx_act`, each one clock later. In `tx_src`, 0 means outbound attachment data and 1 means twisted-pair receive data. In `di_src`, 0 means twisted-pair receive data and 1 means outbound attachment data.
- R3: `xmt` is high whenever the twisted-pair transmitter is carrying data, and `rcv` is high whenever the inbound attachment pair is carrying data. In normal mode this makes them the one-clock-delayed copies of `aui_do_act` and `tp_rx_act`.
- R4: In normal mode, when `aui_do_act` and `tp_rx_act` are high together, `xmt`, `rcv` and `ci_en` are all high one clock later. This holds whatever the state of `link_ok` or `sqe_test_n`.
- R5: With `tp_test` low and `sqe_test_n` low (station loopback), the paths are the same as in R2. `ci_en` stays low even when both paths are busy.
- R6: With `tp_test` low and `sqe_test_n` high (repeater loopback), `tx_src` and `di_src` are both 1. `tx_en` and `xmt` follow `tp_rx_act`, `di_en` and `rcv` follow `aui_do_act`, and `ci_en` stays low.
- R7: In normal mode with `sqe_test_n` low and `link_ok` high, `ci_en` rises exactly SQE_GAP_CYC clocks after `xmt` falls and stays high for exactly SQE_LEN_CYC clocks (defaults 8 and 10). While this burst is high, `xmt` is low.
- R8: With `sqe_test_n` high, no heartbeat burst is produced after a transmission.
- R9: No heartbeat burst appears in either loopback mode. A pending or running burst is dropped in the clock after `link_ok` goes low.
- R10: New outbound activity before the burst starts cancels the pending burst. The gap is then timed again from the end of the new transmission.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one period stands for one bit time by default |
| rst_n | input | 1 | Active-low reset, asserted asynchronously, released through a synchronizer |
| tp_test | input | 1 | High: normal operation; low: loopback |
| sqe_test_n | input | 1 | Active-low heartbeat enable; also selects the loopback routing |
| link_ok | input | 1 | High while the twisted-pair link is judged good |
| aui_do_act | input | 1 | Activity on the outbound attachment data pair |
| tp_rx_act | input | 1 | Activity on the twisted-pair receiver |
| tx_en | output | 1 | Enable for the twisted-pair transmitter |
| tx_src | output | 1 | Transmitter source select (0 outbound attachment data, 1 twisted-pair receive) |
| di_en | output | 1 | Enable for the inbound attachment data driver |
| di_src | output | 1 | Inbound data source select (0 twisted-pair receive, 1 outbound attachment data) |
| xmt | output | 1 | Transmit activity flag |
| rcv | output | 1 | Receive activity flag |
| ci_en | output | 1 | Enable for the control signal toward the station (collision or heartbeat) |

## Verification
The properties compare outputs with inputs sampled one clock earlier. They therefore take for granted that the inputs are quiet while the reset synchronizer is still holding the logic after `rst_n` rises. During that window `tp_test` must be high and both activity inputs low. The stimulus keeps exactly those values through every reset and for several clocks after each release. It changes mode and activity only on falling clock edges, so each registered output has one settled input set to follow.

// File: rtl/mau_pkg.sv
package mau_pkg;

  typedef enum logic [1:0] {
    MODE_NORMAL = 2'd0,
    MODE_STA_LB = 2'd1,
    MODE_REP_LB = 2'd2
  } mau_mode_e;

  typedef enum logic [1:0] {
    HB_IDLE  = 2'd0,
    HB_WAIT  = 2'd1,
    HB_BURST = 2'd2
  } hb_state_e;

  typedef struct packed {
    logic tx_en;
    logic tx_src;
    logic di_en;
    logic di_src;
    logic xmt;
    logic rcv;
    logic coll;
  } mau_ctl_s;

  localparam logic TX_FROM_AUI = 1'b0;
  localparam logic TX_FROM_TP  = 1'b1;
  localparam logic DI_FROM_TP  = 1'b0;
  localparam logic DI_FROM_AUI = 1'b1;

endpackage

// File: rtl/mau_rst_sync.sv
module mau_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];

endmodule

// File: rtl/mau_route.sv
module mau_route
  import mau_pkg::*;
(
  input  mau_mode_e mode,
  input  logic      do_act,
  input  logic      rx_act,
  output mau_ctl_s  ctl
);

  always_comb begin
    ctl = '0;
    unique case (mode)
      MODE_NORMAL: begin
        ctl.tx_en  = do_act;
        ctl.tx_src = TX_FROM_AUI;
        ctl.di_en  = rx_act;
        ctl.di_src = DI_FROM_TP;
        ctl.xmt    = do_act;
        ctl.rcv    = rx_act;
        ctl.coll   = do_act & rx_act;
      end
      MODE_STA_LB: begin
        ctl.tx_en  = do_act;
        ctl.tx_src = TX_FROM_AUI;
        ctl.di_en  = rx_act;
        ctl.di_src = DI_FROM_TP;
        ctl.xmt    = do_act;
        ctl.rcv    = rx_act;
        ctl.coll   = 1'b0;
      end
      MODE_REP_LB: begin
        ctl.tx_en  = rx_act;
        ctl.tx_src = TX_FROM_TP;
        ctl.di_en  = do_act;
        ctl.di_src = DI_FROM_AUI;
        ctl.xmt    = rx_act;
        ctl.rcv    = do_act;
        ctl.coll   = 1'b0;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mau_sqe_timer.sv
module mau_sqe_timer
  import mau_pkg::*;
#(
  parameter int GAP_CYC   = 8,
  parameter int BURST_CYC = 10
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic tx_act,
  output logic burst
);

  localparam int MAX_CYC = (GAP_CYC > BURST_CYC) ? GAP_CYC : BURST_CYC;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);
  localparam logic [CNT_W-1:0] GAP_LAST   = CNT_W'(GAP_CYC - 1);
  localparam logic [CNT_W-1:0] BURST_LAST = CNT_W'(BURST_CYC - 1);

  hb_state_e        state_q, state_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;
  logic             tx_q;

  always_comb begin
    state_d = state_q;
    cnt_d   = cnt_q;
    cnt_en  = 1'b0;
    if (!arm || tx_act) begin
      state_d = HB_IDLE;
      cnt_d   = '0;
      cnt_en  = 1'b1;
    end else begin
      unique case (state_q)
        HB_IDLE: begin
          if (tx_q) begin
            state_d = HB_WAIT;
            cnt_d   = '0;
            cnt_en  = 1'b1;
          end
        end
        HB_WAIT: begin
          cnt_en = 1'b1;
          if (cnt_q == GAP_LAST) begin
            state_d = HB_BURST;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        HB_BURST: begin
          cnt_en = 1'b1;
          if (cnt_q == BURST_LAST) begin
            state_d = HB_IDLE;
            cnt_d   = '0;
          end else begin
            cnt_d = cnt_q + 1'b1;
          end
        end
        default: begin
          state_d = HB_IDLE;
          cnt_d   = '0;
          cnt_en  = 1'b1;
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= HB_IDLE;
      tx_q    <= 1'b0;
    end else begin
      state_q <= state_d;
      tx_q    <= tx_act;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_d;
    end
  end

  assign burst = (state_q == HB_BURST);

endmodule

// File: rtl/mau_loop_ctrl.sv
module mau_loop_ctrl
  import mau_pkg::*;
#(
  parameter int SQE_GAP_CYC = 8,
  parameter int SQE_LEN_CYC = 10,
  parameter int RST_STAGES  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tp_test,
  input  logic sqe_test_n,
  input  logic link_ok,
  input  logic aui_do_act,
  input  logic tp_rx_act,
  output logic tx_en,
  output logic tx_src,
  output logic di_en,
  output logic di_src,
  output logic xmt,
  output logic rcv,
  output logic ci_en
);

  logic      rst_int_n;
  mau_mode_e mode;
  mau_ctl_s  ctl_d, ctl_q;
  logic      hb_arm;
  logic      hb_burst;

  mau_rst_sync #(
    .STAGES(RST_STAGES)
  ) i_rst_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_sync_n(rst_int_n)
  );

  always_comb begin
    if (tp_test) begin
      mode = MODE_NORMAL;
    end else if (sqe_test_n) begin
      mode = MODE_REP_LB;
    end else begin
      mode = MODE_STA_LB;
    end
  end

  assign hb_arm = (mode == MODE_NORMAL) && !sqe_test_n && link_ok;

  mau_route i_route (
    .mode  (mode),
    .do_act(aui_do_act),
    .rx_act(tp_rx_act),
    .ctl   (ctl_d)
  );

  mau_sqe_timer #(
    .GAP_CYC  (SQE_GAP_CYC),
    .BURST_CYC(SQE_LEN_CYC)
  ) i_sqe_timer (
    .clk   (clk),
    .rst_n (rst_int_n),
    .arm   (hb_arm),
    .tx_act(aui_do_act),
    .burst (hb_burst)
  );

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      ctl_q <= '0;
    end else begin
      ctl_q <= ctl_d;
    end
  end

  assign tx_en  = ctl_q.tx_en;
  assign tx_src = ctl_q.tx_src;
  assign di_en  = ctl_q.di_en;
  assign di_src = ctl_q.di_src;
  assign xmt    = ctl_q.xmt;
  assign rcv    = ctl_q.rcv;
  assign ci_en  = ctl_q.coll | hb_burst;

endmodule

// File: rtl/mau_loop_ctrl_chk.sv
module mau_loop_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic tp_test,
  input logic sqe_test_n,
  input logic link_ok,
  input logic aui_do_act,
  input logic tp_rx_act,
  input logic tx_en,
  input logic tx_src,
  input logic di_en,
  input logic di_src,
  input logic xmt,
  input logic rcv,
  input logic ci_en
);

  AST_RST_QUIET: assert property (@(posedge clk)
    !rst_n |-> !(tx_en || tx_src || di_en || di_src || xmt || rcv || ci_en)); // R1

  AST_NORMAL_PATH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tp_test) |-> !tx_src && !di_src && (tx_en == $past(aui_do_act)) && (di_en == $past(tp_rx_act))); // R2

  AST_NORMAL_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tp_test) |-> (xmt == $past(aui_do_act)) && (rcv == $past(tp_rx_act))); // R3

  AST_COLLISION_ALL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    $past(tp_test && aui_do_act && tp_rx_act) |-> xmt && rcv && ci_en); // R4

  AST_STATION_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tp_test && !sqe_test_n) |-> !tx_src && !di_src && !ci_en); // R5

  AST_REPEATER_ROUTE: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tp_test && sqe_test_n) |-> tx_src && di_src && (xmt == $past(tp_rx_act)) && (rcv == $past(aui_do_act))); // R6

  AST_BURST_TX_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    (ci_en && !rcv) |-> !xmt); // R7

  AST_HB_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    $past(sqe_test_n && !(aui_do_act && tp_rx_act)) |-> !ci_en); // R8

  AST_LINK_FAIL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!link_ok && !(aui_do_act && tp_rx_act)) |-> !ci_en); // R9

  AST_LOOP_NO_CI: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!tp_test) |-> !ci_en); // R9

endmodule

bind mau_loop_ctrl mau_loop_ctrl_chk i_mau_loop_ctrl_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .tp_test   (tp_test),
  .sqe_test_n(sqe_test_n),
  .link_ok   (link_ok),
  .aui_do_act(aui_do_act),
  .tp_rx_act (tp_rx_act),
  .tx_en     (tx_en),
  .tx_src    (tx_src),
  .di_en     (di_en),
  .di_src    (di_src),
  .xmt       (xmt),
  .rcv       (rcv),
  .ci_en     (ci_en)
);

// File: tb/test_mau_loop_ctrl.sv
module test_mau_loop_ctrl;

  localparam int GAP = 8;
  localparam int LEN = 10;
  localparam int NVEC = 13;

  logic clk;
  logic rst_n;
  logic tp_test, sqe_test_n, link_ok, aui_do_act, tp_rx_act;
  logic tx_en, tx_src, di_en, di_src, xmt, rcv, ci_en;
  logic [6:0] obs;

  int n_checks;
  int n_fail;
  logic done;

  assign obs = {tx_en, tx_src, di_en, di_src, xmt, rcv, ci_en};

  mau_loop_ctrl #(
    .SQE_GAP_CYC(GAP),
    .SQE_LEN_CYC(LEN),
    .RST_STAGES (2)
  ) i_mau_loop_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .tp_test   (tp_test),
    .sqe_test_n(sqe_test_n),
    .link_ok   (link_ok),
    .aui_do_act(aui_do_act),
    .tp_rx_act (tp_rx_act),
    .tx_en     (tx_en),
    .tx_src    (tx_src),
    .di_en     (di_en),
    .di_src    (di_src),
    .xmt       (xmt),
    .rcv       (rcv),
    .ci_en     (ci_en)
  );

  initial clk = 1'b0;
  always #2 clk = ~clk;

  // inputs {tp_test, sqe_test_n, link_ok, aui_do_act, tp_rx_act},
  // expected {tx_en, tx_src, di_en, di_src, xmt, rcv, ci_en}
  localparam logic [11:0] VEC [NVEC] = '{
    {5'b11100, 7'b0000000},
    {5'b11110, 7'b1000100},
    {5'b11101, 7'b0010010},
    {5'b11111, 7'b1010111},
    {5'b11011, 7'b1010111},
    {5'b00110, 7'b1000100},
    {5'b00111, 7'b1010110},
    {5'b00101, 7'b0010010},
    {5'b01101, 7'b1101100},
    {5'b01110, 7'b0111010},
    {5'b01111, 7'b1111110},
    {5'b01100, 7'b0101000},
    {5'b11100, 7'b0000000}
  };

  task automatic report();
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
  endtask

  task automatic chk(input string tag, input logic [6:0] got, input logic [6:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, got, exp);
    end
  endtask

  function automatic string vec_tag(input logic [4:0] in);
    if (in[4] && in[1] && in[0]) return "R4";
    if (in[4])                   return "R2 R3";
    if (!in[3])                  return "R5";
    return "R6";
  endfunction

  task automatic send_tx(input int cycles);
    @(negedge clk);
    aui_do_act = 1'b1;
    repeat (cycles) @(negedge clk);
    aui_do_act = 1'b0;
  endtask

  task automatic watch_ci(input string tag, input logic expect_burst, input int span);
    for (int k = 0; k < span; k++) begin
      logic e;
      @(negedge clk);
      e = expect_burst && (k >= GAP) && (k < GAP + LEN);
      chk(tag, {6'b0, ci_en}, {6'b0, e});
    end
  endtask

  initial begin
    n_checks = 0;
    n_fail = 0;
    done = 1'b0;
    rst_n = 1'b1;
    tp_test = 1'b1;
    sqe_test_n = 1'b1;
    link_ok = 1'b1;
    aui_do_act = 1'b0;
    tp_rx_act = 1'b0;
    #1 rst_n = 1'b0;

    // R1: outputs idle in reset, also with activity pending at the inputs
    repeat (2) @(negedge clk);
    chk("R1 in reset", obs, 7'b0);
    aui_do_act = 1'b1;
    tp_rx_act = 1'b1;
    @(negedge clk);
    chk("R1 reset ignores activity", obs, 7'b0);
    aui_do_act = 1'b0;
    tp_rx_act = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 release held by synchronizer", obs, 7'b0);
    repeat (3) @(negedge clk);

    // table walk
    for (int i = 0; i < NVEC; i++) begin
      {tp_test, sqe_test_n, link_ok, aui_do_act, tp_rx_act} = VEC[i][11:7];
      @(negedge clk);
      chk(vec_tag(VEC[i][11:7]), obs, VEC[i][6:0]);
    end

    // R7: heartbeat timing after a transmission
    tp_test = 1'b1;
    sqe_test_n = 1'b0;
    link_ok = 1'b1;
    send_tx(5);
    watch_ci("R7 heartbeat window", 1'b1, GAP + LEN + 3);

    // R10: new transmission during the gap restarts timing
    send_tx(3);
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R10 gap before restart", {6'b0, ci_en}, 7'b0);
    end
    aui_do_act = 1'b1;
    repeat (3) @(negedge clk);
    chk("R10 transmit flag during restart", {5'b0, xmt, ci_en}, 7'b0000010);
    aui_do_act = 1'b0;
    watch_ci("R10 heartbeat after restart", 1'b1, GAP + LEN + 3);

    // R8: heartbeat disabled
    sqe_test_n = 1'b1;
    send_tx(4);
    watch_ci("R8 no heartbeat when disabled", 1'b0, GAP + LEN + 3);

    // R9: station loopback never produces a burst
    tp_test = 1'b0;
    sqe_test_n = 1'b0;
    send_tx(4);
    watch_ci("R9 no heartbeat in loopback", 1'b0, GAP + LEN + 3);

    // R9: link failure during the gap drops the burst
    tp_test = 1'b1;
    repeat (2) @(negedge clk);
    send_tx(4);
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
    end
    link_ok = 1'b0;
    watch_ci("R9 link failure drops heartbeat", 1'b0, GAP + LEN + 3);
    link_ok = 1'b1;

    // R9: link failure in the middle of a burst ends it one clock later
    send_tx(4);
    for (int k = 0; k < GAP + 2; k++) begin
      @(negedge clk);
    end
    chk("R9 burst running before link loss", {6'b0, ci_en}, 7'b1);
    link_ok = 1'b0;
    @(negedge clk);
    chk("R9 burst ended by link loss", {6'b0, ci_en}, 7'b0);
    link_ok = 1'b1;
    repeat (LEN + 2) @(negedge clk);

    // R4: collision with heartbeat disabled and link down
    sqe_test_n = 1'b1;
    link_ok = 1'b0;
    aui_do_act = 1'b1;
    tp_rx_act = 1'b1;
    @(negedge clk);
    chk("R4 collision regardless of link", obs, 7'b1010111);
    aui_do_act = 1'b0;
    tp_rx_act = 1'b0;
    link_ok = 1'b1;
    @(negedge clk);

    // R1: asynchronous reset while active
    aui_do_act = 1'b1;
    @(negedge clk);
    chk("R3 transmit before reset", {5'b0, xmt, ci_en}, 7'b0000010);
    #1 rst_n = 1'b0;
    #0.5;
    chk("R1 asynchronous clear", obs, 7'b0);
    aui_do_act = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 idle after release", obs, 7'b0);

    done = 1'b1;
    report();
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      report();
      $finish;
    end
  end

endmodule